// File: doc/BRIEF.md
# Normalization Shift-Amount Unit

This unit takes a 32-bit operand and reports how many places it has to move left so that its most significant bit becomes significant. The shift itself is done elsewhere. Two modes are offered. Unsigned mode counts the zero bits above the highest one bit. Signed mode counts how far a two's-complement value can move before its sign bit and the bit below it differ.

The operand, the mode select and a valid strobe are sampled together on a rising clock edge. The shift amount appears on a 6-bit output one cycle later, with a valid flag. While the strobe is low the previous result is held. The count is a priority search from the top bit down, and both modes share that one search.

Top module: `norm_shift_amt`

## Requirements
- R1: While reset is asserted (rst_n low), and in the first cycle after it, out_valid is 0 and out_shift is 0.
- R2: out_valid equals the in_valid value that was sampled on the previous rising clock edge.
- R3: When in_valid is low at an edge, out_shift keeps its previous value.
- R4: In unsigned mode (in_signed = 0), out_shift is the number of zero bits above the highest set bit of in_data. An operand with bit 31 set gives 0.
- R5: In unsigned mode, an operand of zero gives 32.
- R6: In signed mode (in_signed = 1), for an operand with bit 31 clear, out_shift is its leading-zero count minus one. An operand whose bits 31 and 30 differ gives 0.
- R7: In signed mode, an operand with bit 31 set is bitwise inverted first, and out_shift is the leading-zero count of the inverted value minus one.
- R8: In signed mode, both 0 and all-ones give 31. No signed result exceeds 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 32 | Operand |
| in_signed | input | 1 | 1 = signed mode, 0 = unsigned mode |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_shift | output | 6 | Shift amount |

## Verification
The bench builds the unit with its default 32-bit operand width, which gives a 6-bit result. At that width it can reach every count from 0 to 32, including the two fixed zero-operand values, 31 and 32. Random operands are shifted right by a random amount, so that every leading-zero depth is hit in both modes. Idle cycles with the strobe low and random data on the inputs test that the result is held.

// File: rtl/norm_shift_amt.sv
module norm_shift_amt #(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_signed,
  output logic              out_valid,
  output logic [CNT_W-1:0]  out_shift
);

  logic [DATA_W-1:0] scan_src;
  logic [CNT_W-1:0]  zcount;
  logic [CNT_W-1:0]  shift_next;
  logic              hit;

  // a signed operand is folded onto its magnitude pattern, so bit 31 is always clear
  assign scan_src = in_signed ? (in_data ^ {DATA_W{in_data[DATA_W-1]}}) : in_data;

  always_comb begin
    zcount = CNT_W'(DATA_W);
    hit    = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (!hit && scan_src[i]) begin
        zcount = CNT_W'(DATA_W - 1 - i);
        hit    = 1'b1;
      end
    end
  end

  // signed: the count is at least 1, and a zero source gives DATA_W-1
  assign shift_next = in_signed ? zcount - CNT_W'(1) : zcount;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_shift <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_shift <= shift_next;
    end
  end

endmodule

module norm_shift_amt_chk #(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              in_signed,
  input logic              out_valid,
  input logic [CNT_W-1:0]  out_shift
);

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_shift == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_shift));

  a_r4_msb_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_signed && in_data[DATA_W-1]) |=> out_shift == '0);

  a_r5_zero_unsigned: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_signed && in_data == '0) |=> out_shift == CNT_W'(DATA_W));

  a_r6_sign_change: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_signed && (in_data[DATA_W-1] != in_data[DATA_W-2])) |=> out_shift == '0);

  a_r7_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_signed && in_data == '1) |=> out_shift == CNT_W'(DATA_W - 1));

  a_r8_signed_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_signed) |=> out_shift <= CNT_W'(DATA_W - 1));

  a_r8_zero_signed: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_signed && in_data == '0) |=> out_shift == CNT_W'(DATA_W - 1));

endmodule

bind norm_shift_amt norm_shift_amt_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_signed(in_signed), .out_valid(out_valid), .out_shift(out_shift)
);

// File: tb/test_norm_shift_amt.sv
module test_norm_shift_amt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_signed = 1'b0;
  logic        out_valid;
  logic [5:0]  out_shift;
  int checks = 0;
  int failures = 0;
  logic [5:0] last_exp = '0;

  always #10 clk = ~clk;

  norm_shift_amt i_norm_shift_amt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_signed(in_signed), .out_valid(out_valid), .out_shift(out_shift)
  );

  // shift the operand left one place at a time until its top bit is set
  function automatic int zeros_above(input logic [31:0] v);
    int n = 0;
    logic [31:0] t = v;
    if (v == 0) return 32;
    while (!t[31]) begin
      t = t << 1;
      n++;
    end
    return n;
  endfunction

  function automatic logic [5:0] model(input logic [31:0] d, input logic sgn);
    logic [31:0] v;
    if (!sgn) return 6'(zeros_above(d));
    v = d[31] ? ~d : d;
    if (v == 0) return 6'd31;
    return 6'(zeros_above(v) - 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] d, input logic sgn, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_signed = sgn;
    last_exp = model(d, sgn);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {31'd0, out_valid}, 32'd1);
    check(req, {26'd0, out_shift}, {26'd0, last_exp});
  endtask

  task automatic idle(input logic [31:0] d, input logic sgn);
    @(negedge clk);
    in_valid = 1'b0; in_data = d; in_signed = sgn;
    @(negedge clk);
    check("R2", {31'd0, out_valid}, 32'd0);
    check("R3", {26'd0, out_shift}, {26'd0, last_exp});
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", {31'd0, out_valid}, 32'd0);
    check("R1", {26'd0, out_shift}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {31'd0, out_valid}, 32'd0);

    apply(32'h0000_0000, 1'b0, "R5");
    apply(32'h8000_0000, 1'b0, "R4");
    apply(32'h0000_0001, 1'b0, "R4");
    apply(32'hFFFF_FFFF, 1'b0, "R4");
    apply(32'h0001_2345, 1'b0, "R4");
    apply(32'h0000_0000, 1'b1, "R8");
    apply(32'hFFFF_FFFF, 1'b1, "R8");
    apply(32'h4000_0000, 1'b1, "R6");
    apply(32'h0000_0001, 1'b1, "R6");
    apply(32'h8000_0000, 1'b1, "R7");
    apply(32'hFFFF_FFFE, 1'b1, "R7");
    apply(32'hFFF0_1234, 1'b1, "R7");
    idle(32'h0000_0000, 1'b0);
    idle(32'hFFFF_FFFF, 1'b1);

    for (int k = 0; k < 3000; k++) begin
      logic [31:0] d;
      logic sgn;
      d   = $urandom() >> ($urandom() % 33);
      sgn = 1'($urandom());
      if (sgn && $urandom() % 2 == 0) d = ~d;
      if ($urandom() % 5 == 0) idle(d, sgn);
      else apply(d, sgn, sgn ? (d[31] ? "R7" : "R6") : "R4");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule